// File: doc/BRIEF.md
# Three-Operand Arithmetic and Logic Unit with Signed-Count Shifter

This block is the combinational datapath of a three-operand processor. It takes the top four bits of an instruction word together with two source operands, here called the base operand and the control operand, and produces the destination value in the same cycle. Opcodes with leading bits `01` form the arithmetic group: add, subtract and two shifts. Opcodes with leading bits `10` form the logical group: AND, OR, bit-clear and XOR. A valid flag marks the opcodes that belong to either group, so that the surrounding pipeline knows when to write the result back.

Both shifts take their count from the control operand, read as a two's complement number. A positive count moves the base operand left and a negative count moves it right. The zero-fill shift clears every vacated bit. The sign-fill shift feeds in the current top bit at each single-bit step. Going right, this is an arithmetic shift. Going left, the top bit wraps into bit 0, so the shift becomes a rotate. Counts whose magnitude reaches the word width are fully defined. Register file access and condition flags stay outside the block.

Top module: `alu3_core`

## Requirements
- R1: `valid` is 1 exactly when `opcode[3:2]` is `01` or `10`. For every other opcode, `result` is all zeros.
- R2: Opcode `0100` (add) gives `result = base + ctrl` modulo 2^16, and the carry out is dropped.
- R3: Opcode `0101` (subtract) gives `result = base - ctrl` modulo 2^16.
- R4: The logical opcodes are `1000` AND, `1001` OR, `1010` bit-clear (`base & ~ctrl`) and `1011` XOR.
- R5: For both shift opcodes, `ctrl` is a signed two's complement count. A positive count shifts left, a negative count shifts right, and a count of zero returns `base` unchanged.
- R6: Opcode `0110` (zero-fill shift) fills vacated bits with 0. A count magnitude of 16 or more gives 0 in either direction.
- R7: Opcode `0111` (sign-fill shift) with a negative count is an arithmetic right shift. A magnitude of 16 or more gives 16 copies of `base[15]`.
- R8: Opcode `0111` with a positive count rotates `base` left by the count modulo 16.
- R9: A count of -32768 is treated as a right shift of magnitude 32768. Opcode `0110` then gives 0 and opcode `0111` gives all copies of `base[15]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Top four bits of the instruction word |
| base | input | 16 | First source operand; the value that is shifted |
| ctrl | input | 16 | Second source operand; the signed count for the shifts |
| result | output | 16 | Destination value |
| valid | output | 1 | High when the opcode is in the arithmetic or logical group |

## Verification
The bench builds the block with its default width of 16. At this width, every opcode can be stepped through, and each shift boundary can be reached with directed values: counts of 15, 16, 17, -16, -32768 and 32767. The count -32768 only behaves as a corner case at this exact width, because it is the one negative value with no positive counterpart. The reference model shifts one bit at a time, so the barrel stages are checked against a structure that is different from theirs. Pseudo-random operands, with counts biased towards small magnitudes, then cover the ordinary shift amounts for every opcode.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 4'b0100,
      OPC_SUB  = 4'b0101,
      OPC_SHZ  = 4'b0110,
      OPC_SHS  = 4'b0111,
      OPC_AND  = 4'b1000,
      OPC_OR   = 4'b1001,
      OPC_BCLR = 4'b1010,
      OPC_XOR  = 4'b1011
   } alu_opc_e;

   typedef enum logic [1:0] {
      GRP_NONE  = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_LOGIC = 2'd2
   } alu_grp_e;

   typedef enum logic [1:0] {
      SEL_ADDSUB = 2'd0,
      SEL_SHIFT  = 2'd1,
      SEL_LOGIC  = 2'd2,
      SEL_ZERO   = 2'd3
   } alu_sel_e;

   typedef struct packed {
      alu_sel_e   sel;
      logic       sub;
      logic       sign_fill;
      logic [1:0] lop;
      logic       valid;
   } alu_ctl_t;

endpackage

// File: rtl/alu3_decode.sv
module alu3_decode
   import alu3_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output alu_ctl_t         ctl
);

   alu_grp_e grp;

   always_comb begin
      unique case (opcode[OPC_W-1:OPC_W-2])
         2'b01:   grp = GRP_ARITH;
         2'b10:   grp = GRP_LOGIC;
         default: grp = GRP_NONE;
      endcase
   end

   always_comb begin
      ctl           = '0;
      ctl.sel       = SEL_ZERO;
      ctl.lop       = opcode[1:0];
      ctl.sub       = 1'b0;
      ctl.sign_fill = 1'b0;
      ctl.valid     = 1'b0;
      case (grp)
         GRP_ARITH: begin
            ctl.valid = 1'b1;
            if (opcode[1]) begin
               ctl.sel       = SEL_SHIFT;
               ctl.sign_fill = opcode[0];
            end else begin
               ctl.sel = SEL_ADDSUB;
               ctl.sub = opcode[0];
            end
         end
         GRP_LOGIC: begin
            ctl.valid = 1'b1;
            ctl.sel   = SEL_LOGIC;
         end
         default: begin
            ctl.sel = SEL_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/alu3_addsub.sv
module alu3_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum
);

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;

   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
   assign sum   = full[WIDTH-1:0];

endmodule

// File: rtl/alu3_logic.sv
module alu3_logic #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       lop,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (lop)
         2'b00: y = a & b;
         2'b01: y = a | b;
         2'b10: y = a & ~b;
         2'b11: y = a ^ b;
      endcase
   end

endmodule

// File: rtl/alu3_shift.sv
module alu3_shift #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] val,
   input  logic [WIDTH-1:0] cnt,
   input  logic             sign_fill,
   output logic [WIDTH-1:0] y
);

   localparam int STAGES = $clog2(WIDTH);

   logic             neg;
   logic [WIDTH-1:0] mag;
   logic             big;
   logic             fill_r;
   logic [WIDTH-1:0] lstg [0:STAGES];
   logic [WIDTH-1:0] rstg [0:STAGES];

   assign neg    = cnt[WIDTH-1];
   assign mag    = neg ? (~cnt + WIDTH'(1)) : cnt;
   assign big    = |mag[WIDTH-1:STAGES];
   assign fill_r = sign_fill & val[WIDTH-1];

   assign lstg[0] = val;
   assign rstg[0] = val;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [WIDTH-1:0] l_next;
      logic [WIDTH-1:0] r_next;

      if (S < WIDTH) begin : g_ok
         always_comb begin
            if (sign_fill)
               l_next = {lstg[k][WIDTH-1-S:0], lstg[k][WIDTH-1:WIDTH-S]};
            else
               l_next = {lstg[k][WIDTH-1-S:0], {S{1'b0}}};
            r_next = {{S{fill_r}}, rstg[k][WIDTH-1:S]};
         end
      end else begin : g_bad
         assign l_next = lstg[k];
         assign r_next = rstg[k];
      end

      assign lstg[k+1] = mag[k] ? l_next : lstg[k];
      assign rstg[k+1] = mag[k] ? r_next : rstg[k];
   end

   always_comb begin
      if (!neg)
         y = (big && !sign_fill) ? '0 : lstg[STAGES];
      else
         y = big ? {WIDTH{fill_r}} : rstg[STAGES];
   end

endmodule

// File: rtl/alu3_core.sv
module alu3_core
   import alu3_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [3:0]       opcode,
   input  logic [WIDTH-1:0] base,
   input  logic [WIDTH-1:0] ctrl,
   output logic [WIDTH-1:0] result,
   output logic             valid
);

   if (WIDTH < 4) begin : g_chk_min
      $error("alu3_core: WIDTH must be at least 4");
   end
   if ((WIDTH & (WIDTH - 1)) != 0) begin : g_chk_pow2
      $error("alu3_core: WIDTH must be a power of two");
   end

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] as_y;
   logic [WIDTH-1:0] sh_y;
   logic [WIDTH-1:0] lg_y;

   alu3_decode u_dec (
      .opcode (opcode),
      .ctl    (ctl)
   );

   alu3_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a   (base),
      .b   (ctrl),
      .sub (ctl.sub),
      .sum (as_y)
   );

   alu3_shift #(.WIDTH(WIDTH)) u_shift (
      .val       (base),
      .cnt       (ctrl),
      .sign_fill (ctl.sign_fill),
      .y         (sh_y)
   );

   alu3_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (base),
      .b   (ctrl),
      .lop (ctl.lop),
      .y   (lg_y)
   );

   always_comb begin
      unique case (ctl.sel)
         SEL_ADDSUB: result = as_y;
         SEL_SHIFT:  result = sh_y;
         SEL_LOGIC:  result = lg_y;
         default:    result = '0;
      endcase
   end

   assign valid = ctl.valid;

endmodule

// File: rtl/alu3_checker.sv
module alu3_checker #(
   parameter int WIDTH = 16
) (
   input logic [3:0]       opcode,
   input logic [WIDTH-1:0] base,
   input logic [WIDTH-1:0] ctrl,
   input logic [WIDTH-1:0] result,
   input logic             valid
);

   always_comb begin
      AST_VALID_GROUP: assert (valid == (opcode[3] ^ opcode[2])); // R1
      if (!valid) begin
         AST_IDLE_ZERO: assert (result == '0); // R1
      end
      if (opcode == 4'b0100) begin
         AST_ADD_INVERSE: assert (WIDTH'(result - ctrl) == base); // R2
      end
      if (opcode == 4'b0101) begin
         AST_SUB_INVERSE: assert (WIDTH'(result + ctrl) == base); // R3
      end
      if (opcode == 4'b1000) begin
         AST_AND_SUBSET: assert ((result & ~base) == '0 && (result & ~ctrl) == '0); // R4
      end
      if (opcode == 4'b1011) begin
         AST_XOR_UNDO: assert ((result ^ ctrl) == base); // R4
      end
      if (opcode[3:1] == 3'b011 && ctrl == '0) begin
         AST_ZERO_COUNT: assert (result == base); // R5
      end
      if (opcode == 4'b0110 && !ctrl[WIDTH-1] && ctrl >= WIDTH'(WIDTH)) begin
         AST_ZF_LEFT_FLUSH: assert (result == '0); // R6
      end
      if (opcode == 4'b0111 && ctrl[WIDTH-1]) begin
         AST_SF_RIGHT_SIGN: assert (result[WIDTH-1] == base[WIDTH-1]); // R7
      end
      if (opcode == 4'b0111 && !ctrl[WIDTH-1]) begin
         AST_ROT_POPCOUNT: assert ($countones(result) == $countones(base)); // R8
      end
   end

endmodule

bind alu3_core alu3_checker #(.WIDTH(WIDTH)) u_alu3_checker (
   .opcode (opcode),
   .base   (base),
   .ctrl   (ctrl),
   .result (result),
   .valid  (valid)
);

// File: tb/test_alu3_core.sv
module test_alu3_core;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [3:0]  opcode;
   logic [15:0] base;
   logic [15:0] ctrl;
   logic [15:0] result;
   logic        valid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [15:0] exp_q[$];
   logic        expv_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   alu3_core i_alu3_core (
      .opcode (opcode),
      .base   (base),
      .ctrl   (ctrl),
      .result (result),
      .valid  (valid)
   );

   function automatic logic [15:0] ref_shift(input logic [15:0] v, input logic [15:0] c, input bit sf);
      int          cnt;
      int          steps;
      logic [15:0] x;
      cnt = $signed(c);
      x   = v;
      if (cnt > 0) begin
         steps = sf ? (cnt % 16) : ((cnt > 16) ? 16 : cnt);
         for (int i = 0; i < steps; i++) x = {x[14:0], sf ? x[15] : 1'b0};
      end else if (cnt < 0) begin
         steps = (-cnt > 16) ? 16 : -cnt;
         for (int i = 0; i < steps; i++) x = {sf ? x[15] : 1'b0, x[15:1]};
      end
      return x;
   endfunction

   function automatic logic [15:0] ref_alu(input logic [3:0] op, input logic [15:0] b, input logic [15:0] c);
      int s;
      case (op)
         4'b0100: begin s = int'(b) + int'(c); return s[15:0]; end
         4'b0101: begin s = int'(b) - int'(c); return s[15:0]; end
         4'b0110: return ref_shift(b, c, 1'b0);
         4'b0111: return ref_shift(b, c, 1'b1);
         4'b1000: return b & c;
         4'b1001: return b | c;
         4'b1010: return b & ~c;
         4'b1011: return b ^ c;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic string ref_tag(input logic [3:0] op, input logic [15:0] c);
      if (op[3:2] == 2'b00 || op[3:2] == 2'b11) return "R1";
      if (op == 4'b0100) return "R2";
      if (op == 4'b0101) return "R3";
      if (op[3:2] == 2'b10) return "R4";
      if (c == 16'h0000) return "R5";
      if (c == 16'h8000) return "R9";
      if (op == 4'b0110) return "R6";
      if (c[15]) return "R7";
      return "R8";
   endfunction

   task automatic apply(input logic [3:0] op, input logic [15:0] b, input logic [15:0] c);
      @(posedge clk);
      #1;
      opcode = op;
      base   = b;
      ctrl   = c;
      exp_q.push_back(ref_alu(op, b, c));
      expv_q.push_back(op[3] ^ op[2]);
      tag_q.push_back(ref_tag(op, c));
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         logic        ev;
         string       t;
         e  = exp_q.pop_front();
         ev = expv_q.pop_front();
         t  = tag_q.pop_front();
         checks++;
         if (result !== e) begin
            errors++;
            $display("FAIL %s op=%b b=%h c=%h result actual=%h expected=%h", t, opcode, base, ctrl, result, e);
         end
         checks++;
         if (valid !== ev) begin
            errors++;
            $display("FAIL R1 op=%b valid actual=%b expected=%b", opcode, valid, ev);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      opcode = 4'b0000;
      base   = 16'h0000;
      ctrl   = 16'h0000;
      // R1: initial idle state and every non-ALU opcode
      apply(4'b0000, 16'h0000, 16'h0000);
      for (int op = 0; op < 16; op++) apply(op[3:0], 16'hA5C3, 16'h0003);
      // R2 / R3: wrap-around
      apply(4'b0100, 16'hFFFF, 16'h0001);
      apply(4'b0100, 16'h7FFF, 16'h7FFF);
      apply(4'b0101, 16'h0000, 16'h0001);
      apply(4'b0101, 16'h8000, 16'h0001);
      // R4: logical ops
      apply(4'b1010, 16'hFF00, 16'h0FF0);
      apply(4'b1011, 16'h1234, 16'hFFFF);
      // R5: zero count
      apply(4'b0110, 16'h8421, 16'h0000);
      apply(4'b0111, 16'h8421, 16'h0000);
      // R6: zero-fill boundaries
      apply(4'b0110, 16'hFFFF, 16'd15);
      apply(4'b0110, 16'hFFFF, 16'd16);
      apply(4'b0110, 16'hFFFF, 16'd17);
      apply(4'b0110, 16'hFFFF, 16'hFFF1);
      apply(4'b0110, 16'hFFFF, 16'hFFF0);
      apply(4'b0110, 16'hFFFF, 16'h7FFF);
      // R7: arithmetic right
      apply(4'b0111, 16'h8001, 16'hFFFF);
      apply(4'b0111, 16'h8001, 16'hFFF1);
      apply(4'b0111, 16'h8001, 16'hFFF0);
      apply(4'b0111, 16'h4001, 16'hFFE0);
      // R8: rotate left incl. modulo 16
      apply(4'b0111, 16'h8001, 16'd1);
      apply(4'b0111, 16'h8001, 16'd16);
      apply(4'b0111, 16'h1234, 16'd20);
      apply(4'b0111, 16'h1234, 16'h7FFF);
      // R9: most negative count
      apply(4'b0110, 16'hFFFF, 16'h8000);
      apply(4'b0111, 16'h8000, 16'h8000);
      apply(4'b0111, 16'h7FFF, 16'h8000);
      // pseudo-random sweep
      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] c;
         lf ^= lf << 13;
         lf ^= lf >> 17;
         lf ^= lf << 5;
         c = lf[31:16];
         if (lf[2:1] != 2'b00) c = {{11{lf[8]}}, lf[8:4]};
         apply({lf[3], ~lf[3], lf[10:9]}, lf[26:11], c);
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule